// File: doc/BRIEF.md
# BCD Calendar Clock with Freeze Interface

This block keeps time of day and calendar in packed BCD, from hundredths of a second up to a two-digit year, with hours in 24-hour form. It holds two sets of state. The internal counters advance on a 100 Hz tick enable. A separate set of bus-visible copies is refreshed from the counters once per second, on the tick that rolls hundredths over from 99 to 00. Software reads and writes the copies through a small synchronous register bus. Writes take effect on the clock edge. Read data is combinational from the current address.

Two control bits stop the refresh of the copies. The read freeze holds a coherent snapshot while the counters keep running. The write freeze lets software compose a new time in the copies. When software clears the write freeze, that time is loaded into the counters. A stop bit in the seconds register halts counting. Calibration magnitude and sign bits, a test-enable bit and all spare bits are stored only.

Top module: `bcd_timekeeper`

## Requirements
- R1: Register map, addressed by `bus_addr`:
  - 0: hundredths (00–99).
  - 1: seconds (bits 6:0, 00–59), with the stop bit at bit 7.
  - 2: minutes (bits 6:0).
  - 3: hours (bits 5:0, 00–23).
  - 4: weekday (bits 2:0, 1–7), with a stored test-enable bit at bit 6.
  - 5: date (bits 5:0).
  - 6: month (bits 4:0).
  - 7: year (00–99).
  - 8: control. Bit 7 is the write freeze, bit 6 the read freeze, bit 5 the calibration sign, and bits 4:0 the calibration magnitude.
- R2: After reset, every copy reads 00 except weekday, date and month, which read 01. Control reads 00.
- R3: One second is 100 ticks. The seconds copy does not change before the 100th tick, and on the rolling tick the copies show the new value at the same clock edge. Hundredths then read 00.
- R4: A refresh updates all copies together, including carries through minutes, hours, date, month and year.
- R5: While control bit 6 is 1, the copies hold, but the counters keep counting. After the bit is cleared, the next refresh shows the true time.
- R6: If a write sets control bit 6 on the same edge as a refresh, that refresh still completes before the copies hold.
- R7: While control bit 7 is 1, written copies are kept across rollovers. A write that clears bit 7 loads all copies into the counters, and the next rollover refreshes from the loaded time.
- R8: While seconds bit 7 is 1, counting and refreshing stop. After the bit is cleared, counting resumes and the next rollover refreshes the copies.
- R9: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R10: February ends at 29 when the two-digit year is divisible by 4 (year 00 included), and at 28 otherwise.
- R11: Year 99 wraps to 00, month 12 wraps to 01, and weekday 7 wraps to 1.
- R12: Calibration, test-enable and spare bits are stored and read back as written. A refresh leaves them unchanged.
- R13: Addresses 9 to 15 read 00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse per hundredth of a second |
| bus_addr | input | AW (4) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |

## Verification
A wrong counter value stays hidden until the next rollover, when it reaches the copies. The shortest path from a fault to the ports is therefore up to 100 ticks. A wrong carry or month limit shows only in the refresh that crosses the relevant boundary. For that reason, each calendar case loads a time one tick before the boundary and reads all affected copies immediately afterwards. Freeze faults show as copies that move when they should hold, or that hold when they should move. Each freeze case brackets a rollover with reads before and after it.

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_100hz,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam int NREG = 8;
  localparam int IW = $clog2(NREG);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG);
  localparam logic [8*NREG-1:0] FMASK   = 64'hFF_1F_3F_07_3F_7F_7F_FF;
  localparam logic [8*NREG-1:0] RST_VAL = 64'h00_01_01_01_00_00_00_00;

  logic [7:0] cnt [NREG];
  logic [7:0] vis [NREG];
  logic [7:0] nxt [NREG];
  logic [7:0] ctrl;
  logic [7:0] dlim;
  logic [1:0] lsum;
  logic       roll, halted, leap, refresh, load;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  assign halted  = vis[1][7];
  assign lsum    = cnt[7][1:0] + {cnt[7][4], 1'b0};
  assign leap    = (lsum == 2'b00);
  assign refresh = roll && !ctrl[7] && !ctrl[6];
  assign load    = bus_we && (bus_addr == CTRL_ADDR) && ctrl[7] && !bus_wdata[7];

  always_comb begin
    case (cnt[6])
      8'h02:                      dlim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dlim = 8'h30;
      default:                    dlim = 8'h31;
    endcase
  end

  always_comb begin
    nxt  = cnt;
    roll = 1'b0;
    if (tick_100hz && !halted) begin
      if (cnt[0] != 8'h99) nxt[0] = binc(cnt[0]);
      else begin
        nxt[0] = 8'h00;
        roll   = 1'b1;
        if (cnt[1] != 8'h59) nxt[1] = binc(cnt[1]);
        else begin
          nxt[1] = 8'h00;
          if (cnt[2] != 8'h59) nxt[2] = binc(cnt[2]);
          else begin
            nxt[2] = 8'h00;
            if (cnt[3] != 8'h23) nxt[3] = binc(cnt[3]);
            else begin
              nxt[3] = 8'h00;
              nxt[4] = (cnt[4] == 8'h07) ? 8'h01 : cnt[4] + 8'd1;
              if (cnt[5] != dlim) nxt[5] = binc(cnt[5]);
              else begin
                nxt[5] = 8'h01;
                if (cnt[6] != 8'h12) nxt[6] = binc(cnt[6]);
                else begin
                  nxt[6] = 8'h01;
                  nxt[7] = (cnt[7] == 8'h99) ? 8'h00 : binc(cnt[7]);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        cnt[i] <= RST_VAL[i*8 +: 8];
        vis[i] <= RST_VAL[i*8 +: 8];
      end
      ctrl <= 8'h00;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (load) cnt[i] <= vis[i] & FMASK[i*8 +: 8];
        else      cnt[i] <= nxt[i];
        if (bus_we && bus_addr == AW'(i)) vis[i] <= bus_wdata;
        else if (refresh) vis[i] <= (vis[i] & ~FMASK[i*8 +: 8]) | (nxt[i] & FMASK[i*8 +: 8]);
      end
      if (bus_we && bus_addr == CTRL_ADDR) ctrl <= bus_wdata;
    end
  end

  assign bus_rdata = (bus_addr < AW'(NREG)) ? vis[bus_addr[IW-1:0]] :
                     (bus_addr == CTRL_ADDR) ? ctrl : 8'h00;
endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_100hz,
  input logic       bus_we,
  input logic [7:0] ctrl,
  input logic [7:0] vis_sec,
  input logic [7:0] cnt_hund,
  input logic [7:0] cnt_sec
);
  assert_idle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_100hz && !bus_we |=> $stable(cnt_hund));

  assert_copy_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we && !(tick_100hz && cnt_hund == 8'h99) |=> $stable(vis_sec));

  assert_refresh_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_100hz && cnt_hund == 8'h99 && !vis_sec[7] && ctrl[7:6] == 2'b00 && !bus_we
    |=> vis_sec[6:0] == cnt_sec[6:0]);

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] || ctrl[7]) && !bus_we |=> $stable(vis_sec));

  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vis_sec[7] && !bus_we |=> $stable(cnt_hund) && $stable(cnt_sec));
endmodule

bind bcd_timekeeper bcd_timekeeper_chk chk (
  .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .bus_we(bus_we),
  .ctrl(ctrl), .vis_sec(vis[1]), .cnt_hund(cnt[0]), .cnt_sec(cnt[1])
);

// File: tb/bcd_timekeeper_test.sv
module bcd_timekeeper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bcd_timekeeper uut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] hd, s, m, h, wd, d, mo, y);
    wr(4'd8, 8'h80);
    wr(4'd0, hd); wr(4'd1, s); wr(4'd2, m); wr(4'd3, h);
    wr(4'd4, wd); wr(4'd5, d); wr(4'd6, mo); wr(4'd7, y);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reset;
    rdchk(4'd0, 8'h00, "R1 R2 hund"); rdchk(4'd1, 8'h00, "R2 sec");
    rdchk(4'd2, 8'h00, "R2 min");     rdchk(4'd3, 8'h00, "R2 hour");
    rdchk(4'd4, 8'h01, "R2 wday");    rdchk(4'd5, 8'h01, "R2 date");
    rdchk(4'd6, 8'h01, "R2 month");   rdchk(4'd7, 8'h00, "R2 year");
    rdchk(4'd8, 8'h00, "R2 ctrl");
  endtask

  task automatic t_one_second;
    ticks(99);
    rdchk(4'd1, 8'h00, "R3 before rollover");
    ticks(1);
    rdchk(4'd1, 8'h01, "R3 after 100 ticks");
    rdchk(4'd0, 8'h00, "R3 hundredths copy");
  endtask

  task automatic t_carry;
    set_time(8'h99, 8'h59, 8'h59, 8'h09, 8'h02, 8'h15, 8'h06, 8'h30);
    ticks(1);
    rdchk(4'd3, 8'h10, "R4 hour carry"); rdchk(4'd2, 8'h00, "R4 min");
    rdchk(4'd5, 8'h15, "R4 date unchanged");
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    ticks(1);
    rdchk(4'd1, 8'h00, "R4 sec");   rdchk(4'd2, 8'h00, "R4 min");
    rdchk(4'd3, 8'h00, "R4 hour");  rdchk(4'd4, 8'h01, "R11 wday wrap");
    rdchk(4'd5, 8'h01, "R4 date");  rdchk(4'd6, 8'h01, "R11 month wrap");
    rdchk(4'd7, 8'h00, "R11 year wrap");
  endtask

  task automatic month_case(input logic [7:0] mo, d, y, ed, emo, input string req);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, d, mo, y);
    ticks(1);
    rdchk(4'd5, ed, req);
    rdchk(4'd6, emo, req);
  endtask

  task automatic t_months;
    month_case(8'h04, 8'h30, 8'h21, 8'h01, 8'h05, "R9 april 30");
    month_case(8'h11, 8'h30, 8'h21, 8'h01, 8'h12, "R9 november 30");
    month_case(8'h05, 8'h30, 8'h21, 8'h31, 8'h05, "R9 may 30");
    month_case(8'h01, 8'h31, 8'h21, 8'h01, 8'h02, "R9 january 31");
  endtask

  task automatic t_february;
    month_case(8'h02, 8'h28, 8'h23, 8'h01, 8'h03, "R10 year 23");
    month_case(8'h02, 8'h28, 8'h24, 8'h29, 8'h02, "R10 year 24");
    month_case(8'h02, 8'h29, 8'h24, 8'h01, 8'h03, "R10 29th");
    month_case(8'h02, 8'h28, 8'h00, 8'h29, 8'h02, "R10 year 00");
    month_case(8'h02, 8'h28, 8'h10, 8'h01, 8'h03, "R10 year 10");
    month_case(8'h02, 8'h28, 8'h12, 8'h29, 8'h02, "R10 year 12");
  endtask

  task automatic t_read_freeze;
    set_time(8'h99, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(4'd8, 8'h40);
    ticks(1);
    rdchk(4'd1, 8'h00, "R5 held on rollover");
    ticks(100);
    rdchk(4'd1, 8'h00, "R5 still held");
    rdchk(4'd3, 8'h10, "R5 hour held");
    wr(4'd8, 8'h00);
    ticks(100);
    rdchk(4'd1, 8'h03, "R5 counters ran");
  endtask

  task automatic t_freeze_on_refresh;
    set_time(8'h99, 8'h05, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    @(negedge clk);
    tick_100hz = 1'b1; bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h40;
    @(negedge clk);
    tick_100hz = 1'b0; bus_we = 1'b0;
    rdchk(4'd1, 8'h06, "R6 refresh completed");
    ticks(100);
    rdchk(4'd1, 8'h06, "R6 held after");
    wr(4'd8, 8'h00);
    ticks(100);
    rdchk(4'd1, 8'h08, "R6 resumed");
  endtask

  task automatic t_write_freeze;
    set_time(8'h00, 8'h20, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(4'd8, 8'h80);
    wr(4'd1, 8'h45);
    ticks(100);
    rdchk(4'd1, 8'h45, "R7 written copy kept");
    wr(4'd0, 8'h99);
    wr(4'd2, 8'h12);
    wr(4'd8, 8'h00);
    ticks(1);
    rdchk(4'd1, 8'h46, "R7 loaded seconds");
    rdchk(4'd2, 8'h12, "R7 loaded minutes");
  endtask

  task automatic t_stop;
    set_time(8'h99, 8'h10, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(4'd1, 8'h90);
    ticks(200);
    rdchk(4'd1, 8'h90, "R8 stopped");
    wr(4'd1, 8'h10);
    ticks(1);
    rdchk(4'd1, 8'h11, "R8 restarted");
    rdchk(4'd0, 8'h00, "R8 hundredths");
  endtask

  task automatic t_spare;
    set_time(8'h99, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 8'h01, 8'h20);
    wr(4'd3, 8'hC5);
    wr(4'd4, 8'h41);
    wr(4'd8, 8'h25);
    rdchk(4'd8, 8'h25, "R12 calibration");
    ticks(1);
    rdchk(4'd3, 8'hC5, "R12 hour spare kept");
    rdchk(4'd4, 8'h41, "R12 test bit kept");
    rdchk(4'd1, 8'h01, "R12 refresh occurred");
  endtask

  task automatic t_unmapped;
    wr(4'd12, 8'hFF);
    rdchk(4'd12, 8'h00, "R13 addr 12");
    rdchk(4'd9,  8'h00, "R13 addr 9");
    rdchk(4'd15, 8'h00, "R13 addr 15");
    rdchk(4'd8,  8'h25, "R13 control untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_one_second;
    t_carry;
    t_months;
    t_february;
    t_read_freeze;
    t_freeze_on_refresh;
    t_write_freeze;
    t_stop;
    t_spare;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule